// File: doc/BRIEF.md
# Depthwise 3x3 Line-Buffer Convolver

This block takes a raster stream of multi-channel pixels, one pixel of all channels per cycle, and gives a 3x3 depthwise convolution of it. Each channel is filtered only with its own nine weights. A typical source is a pointwise stage that produces eight channels in parallel. Two row-long line buffers keep the two previous rows. A three-column shift window, fed from those buffers and from the incoming pixel, forms the 3x3 neighbourhood.

The stream is processed in horizontal tiles, each `cfgRows` rows tall and `cfgWidth` pixels wide. Two flags tell the block whether the current tile is the first or the last one of a feature map:
- Zero rows are added above the first tile and below the last tile.
- Left and right zero columns are added on every row.
- Output rows that would depend on a tile's overlap rows are dropped.
- With stride 2, only every other row and every other column is kept.

A bypass control turns the block into a pure pass-through that sign-extends each channel.

Top module: `dw3x3_conv`

## Requirements
- R1: While rstN is low, and after its release until the first kept window, outValid is 0.
- R2: Channel ch of an output is the 32-bit two's-complement sum of nine signed 8x8 products of pixel and weight.
  - The pixel of channel ch is at inData[ch*8 +: 8].
  - The output of channel ch is at outData[ch*32 +: 32].
  - Tap t = 3*dr + dc, where dr and dc run 0..2 from the top-left of the window. Its weight for channel ch is at cfgWeights[(ch*9+t)*8 +: 8].
- R3: Columns -1 and cfgWidth read as zero. Every column 0..cfgWidth-1 of a kept row yields one output, for widths 1 to MAXW.
- R4: With firstTile=1, row 0 of the tile is kept and the row above it reads as zero. With firstTile=0, row 0 yields no output.
- R5: With lastTile=1, row cfgRows-1 is kept and the row below it reads as zero. Those outputs come out without further input. With lastTile=0, row cfgRows-1 yields no output.
- R6: With stride2=1, only centres on an even row and an even column (tile coordinates, counted from 0) yield outputs.
- R7: Outputs leave in raster order, at most one per cycle. An output appears two cycles after the step that completes its window.
- R8: With bypass=1, each valid input appears two cycles later with every channel sign-extended to 32 bits. No convolution outputs are produced.
- R9: The source keeps inValid low for one cycle after the last pixel of every row. After the final row of a last tile it keeps inValid low for cfgWidth+1 further cycles. The configuration is held for the whole tile, with cfgWidth and cfgRows at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input pixel present |
| inData | input | 64 | Eight signed 8-bit channels of one pixel |
| cfgWeights | input | 576 | Nine signed 8-bit taps per channel |
| cfgWidth | input | 5 | Pixels per row of the tile |
| cfgRows | input | 7 | Rows in the tile, overlap rows included |
| firstTile | input | 1 | Tile is the top tile of the map |
| lastTile | input | 1 | Tile is the bottom tile of the map |
| stride2 | input | 1 | Keep only even centres |
| bypass | input | 1 | Pass pixels through unfiltered |
| outValid | output | 1 | Output word present |
| outData | output | 256 | Eight 32-bit channel results |

## Verification
The checks assume the source obeys R9:
- inValid is low during every right-padding step and every bottom-flush step.
- bypass, stride2 and the tile settings change only while the block is at rest between tiles.

The stimulus holds inValid low for exactly the required idle cycles after each row and after a last tile. It changes configuration only after the pipeline has drained, so every window and pass-through timing property can rely on these input rules.

// File: rtl/dw3x3_pkg.sv
package dw3x3_pkg;
  // Per-step strobes from control to datapath
  typedef struct packed {
    logic step;      // advance window by one column
    logic firstCol;  // new column is column 0, left neighbour is padding
    logic padCol;    // right padding column, no pixel consumed
    logic zeroTop;   // upper window row is padding
    logic zeroBot;   // lower window row is padding (bottom flush)
    logic emit;      // window centre is a kept output
  } dwStrobe_t;
endpackage

// File: rtl/dw3x3_ctrl.sv
module dw3x3_ctrl
  import dw3x3_pkg::*;
#(
  parameter int MAXW = 16,
  parameter int MAXH = 64,
  localparam int COLW = $clog2(MAXW + 1),
  localparam int ROWW = $clog2(MAXH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            bypass,
  input  logic            firstTile,
  input  logic            lastTile,
  input  logic            stride2,
  input  logic [COLW-1:0] cfgWidth,
  input  logic [ROWW-1:0] cfgRows,
  output dwStrobe_t       strb,
  output logic [COLW-1:0] colIdx
);
  logic [COLW-1:0] colCnt;
  logic [ROWW-1:0] rowCnt;
  logic padNow, flushNow, stepNow, rowOk, colOk, phaseOk;

  always_comb begin
    padNow   = (colCnt == cfgWidth);
    flushNow = (rowCnt == cfgRows);
    stepNow  = padNow || flushNow || (inValid && !bypass);
    // centre row is rowCnt-1, centre column is colCnt-1
    rowOk    = (rowCnt != '0) && (firstTile || rowCnt >= ROWW'(2));
    colOk    = (colCnt != '0);
    phaseOk  = !stride2 || (rowCnt[0] && colCnt[0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (stepNow) begin
      if (padNow) begin
        colCnt <= '0;
        if (flushNow)                        rowCnt <= '0;
        else if (rowCnt == cfgRows - 1'b1)   rowCnt <= lastTile ? cfgRows : '0;
        else                                 rowCnt <= rowCnt + 1'b1;
      end else begin
        colCnt <= colCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.step     = stepNow;
    strb.firstCol = (colCnt == '0);
    strb.padCol   = padNow;
    strb.zeroTop  = (rowCnt == ROWW'(1));
    strb.zeroBot  = flushNow;
    strb.emit     = stepNow && rowOk && colOk && phaseOk;
    colIdx        = colCnt;
  end
endmodule

// File: rtl/dw3x3_lane.sv
module dw3x3_lane #(
  parameter int DW   = 8,
  parameter int ACCW = 32
) (
  input  logic [9*DW-1:0] taps,
  input  logic [9*DW-1:0] wts,
  output logic [ACCW-1:0] sum
);
  logic signed [2*DW-1:0] prod [9];
  logic signed [ACCW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int t = 0; t < 9; t++) begin
      prod[t] = $signed(taps[t*DW +: DW]) * $signed(wts[t*DW +: DW]);
      acc     = acc + ACCW'(prod[t]);
    end
    sum = acc;
  end
endmodule

// File: rtl/dw3x3_datapath.sv
module dw3x3_datapath
  import dw3x3_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 8,
  parameter int ACCW = 32,
  parameter int MAXW = 16,
  localparam int COLW = $clog2(MAXW + 1),
  localparam int PIXW = NCH * DW
) (
  input  logic                clk,
  input  logic                rstN,
  input  dwStrobe_t           strb,
  input  logic [COLW-1:0]     colIdx,
  input  logic                inValid,
  input  logic                bypass,
  input  logic [PIXW-1:0]     inData,
  input  logic [NCH*9*DW-1:0] cfgWeights,
  output logic                outValid,
  output logic [NCH*ACCW-1:0] outData
);
  typedef logic [PIXW-1:0] pixVec_t;

  pixVec_t lineA [MAXW+1];  // previous row
  pixVec_t lineB [MAXW+1];  // row before that
  pixVec_t win [3][3];      // [column][row], column 2 is newest
  pixVec_t newTop, newMid, newBot, passPix;
  logic winValid, passValid;
  logic [NCH*ACCW-1:0] macSum, passExt;

  always_comb begin
    newTop = (strb.padCol || strb.zeroTop) ? '0 : lineB[colIdx];
    newMid = strb.padCol ? '0 : lineA[colIdx];
    newBot = (strb.padCol || strb.zeroBot) ? '0 : inData;
  end

  always_ff @(posedge clk) begin
    if (strb.step && !strb.padCol) begin
      lineB[colIdx] <= lineA[colIdx];
      lineA[colIdx] <= newBot;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 3; c++)
        for (int r = 0; r < 3; r++) win[c][r] <= '0;
      winValid  <= 1'b0;
      passValid <= 1'b0;
      passPix   <= '0;
    end else begin
      winValid  <= strb.emit;
      passValid <= inValid && bypass;
      passPix   <= inData;
      if (strb.step) begin
        for (int r = 0; r < 3; r++) begin
          win[0][r] <= win[1][r];
          win[1][r] <= strb.firstCol ? '0 : win[2][r];
        end
        win[2][0] <= newTop;
        win[2][1] <= newMid;
        win[2][2] <= newBot;
      end
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic [9*DW-1:0] taps;
    always_comb begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          taps[(r*3+c)*DW +: DW] = win[c][r][ch*DW +: DW];
    end
    dw3x3_lane #(.DW(DW), .ACCW(ACCW)) lane_i (
      .taps(taps),
      .wts (cfgWeights[ch*9*DW +: 9*DW]),
      .sum (macSum[ch*ACCW +: ACCW])
    );
    assign passExt[ch*ACCW +: ACCW] =
      {{(ACCW-DW){passPix[ch*DW+DW-1]}}, passPix[ch*DW +: DW]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= winValid || passValid;
      outData  <= passValid ? passExt : macSum;
    end
  end
endmodule

// File: rtl/dw3x3_conv.sv
module dw3x3_conv
  import dw3x3_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 8,
  parameter int ACCW = 32,
  parameter int MAXW = 16,
  parameter int MAXH = 64,
  localparam int COLW = $clog2(MAXW + 1),
  localparam int ROWW = $clog2(MAXH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [NCH*DW-1:0]   inData,
  input  logic [NCH*9*DW-1:0] cfgWeights,
  input  logic [COLW-1:0]     cfgWidth,
  input  logic [ROWW-1:0]     cfgRows,
  input  logic                firstTile,
  input  logic                lastTile,
  input  logic                stride2,
  input  logic                bypass,
  output logic                outValid,
  output logic [NCH*ACCW-1:0] outData
);
  dwStrobe_t       strb;
  logic [COLW-1:0] colIdx;

  dw3x3_ctrl #(.MAXW(MAXW), .MAXH(MAXH)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .bypass(bypass),
    .firstTile(firstTile), .lastTile(lastTile), .stride2(stride2),
    .cfgWidth(cfgWidth), .cfgRows(cfgRows), .strb(strb), .colIdx(colIdx)
  );

  dw3x3_datapath #(.NCH(NCH), .DW(DW), .ACCW(ACCW), .MAXW(MAXW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .colIdx(colIdx),
    .inValid(inValid), .bypass(bypass), .inData(inData),
    .cfgWeights(cfgWeights), .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/dw3x3_chk.sv
module dw3x3_chk
  import dw3x3_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 8,
  parameter int ACCW = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [NCH*DW-1:0]   inData,
  input logic                bypass,
  input logic                stride2,
  input logic                outValid,
  input logic [NCH*ACCW-1:0] outData,
  input dwStrobe_t           strb
);
  // R8
  bypass_lat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && bypass) |=> ##1 outValid);

  // R8
  bypass_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && bypass) |=> ##1
      (outData[ACCW-1:0] == {{(ACCW-DW){$past(inData[DW-1], 2)}}, $past(inData[DW-1:0], 2)}));

  // R7
  emit_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> ##1 outValid);

  // R6
  stride_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stride2 && !bypass && outValid) |=> !outValid);

  // R9
  pad_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.padCol |-> !inValid);

  // R5
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroBot |-> !inValid);
endmodule

bind dw3x3_conv dw3x3_chk #(.NCH(NCH), .DW(DW), .ACCW(ACCW)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
  .bypass(bypass), .stride2(stride2), .outValid(outValid),
  .outData(outData), .strb(strb)
);

// File: tb/dw3x3_conv_tb.sv
module dw3x3_conv_tb_top;
  localparam int NCH = 8, DW = 8, ACCW = 32, MAXW = 16, MAXH = 64;
  localparam int TBH = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0;
  logic [NCH*DW-1:0] inData = '0;
  logic [NCH*9*DW-1:0] cfgWeights = '0;
  logic [4:0] cfgWidth = 5'd4;
  logic [6:0] cfgRows = 7'd2;
  logic firstTile = 1'b1, lastTile = 1'b1, stride2 = 1'b0, bypass = 1'b0;
  logic outValid;
  logic [NCH*ACCW-1:0] outData;

  int nChk = 0, nFail = 0;
  bit done = 0;
  int img [TBH][MAXW][NCH];
  int wt [NCH][9];
  logic [NCH*ACCW-1:0] gotQ [$];
  logic [NCH*ACCW-1:0] expQ [$];

  always #5 clk = ~clk;

  dw3x3_conv dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .cfgWeights(cfgWeights), .cfgWidth(cfgWidth), .cfgRows(cfgRows),
    .firstTile(firstTile), .lastTile(lastTile), .stride2(stride2),
    .bypass(bypass), .outValid(outValid), .outData(outData)
  );

  always @(negedge clk) if (rstN && outValid) gotQ.push_back(outData);

  task automatic check(bit ok, string req, string what,
                       logic [NCH*ACCW-1:0] act, logic [NCH*ACCW-1:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic loadWeights(int wmode);
    for (int ch = 0; ch < NCH; ch++)
      for (int t = 0; t < 9; t++) begin
        wt[ch][t] = (wmode == 1) ? -128 : (((ch*9 + t) * 29 + 11) % 256) - 128;
        cfgWeights[(ch*9+t)*DW +: DW] = wt[ch][t][7:0];
      end
  endtask

  task automatic runTile(int w, int h, bit first, bit last, bit s2,
                         int pmode, int wmode, int seed, string req);
    @(negedge clk);
    cfgWidth = w[4:0]; cfgRows = h[6:0];
    firstTile = first; lastTile = last; stride2 = s2; bypass = 1'b0;
    loadWeights(wmode);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        for (int ch = 0; ch < NCH; ch++)
          img[r][c][ch] = (pmode == 1) ? -128 : ((r*37 + c*11 + ch*23 + seed) % 256) - 128;
    expQ.delete();
    for (int k = 0; k < h; k++)
      for (int c = 0; c < w; c++)
        if ((k > 0 || first) && (k < h-1 || last) && (!s2 || (k%2 == 0 && c%2 == 0))) begin
          logic [NCH*ACCW-1:0] e;
          for (int ch = 0; ch < NCH; ch++) begin
            int s = 0;
            for (int dr = -1; dr <= 1; dr++)
              for (int dc = -1; dc <= 1; dc++) begin
                int rr = k + dr, cc = c + dc;
                if (rr >= 0 && rr < h && cc >= 0 && cc < w)
                  s += img[rr][cc][ch] * wt[ch][(dr+1)*3 + dc + 1];
              end
            e[ch*ACCW +: ACCW] = s;
          end
          expQ.push_back(e);
        end
    gotQ.delete();
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < w; c++) begin
        inValid = 1'b1;
        for (int ch = 0; ch < NCH; ch++) inData[ch*DW +: DW] = img[r][c][ch][7:0];
        @(negedge clk);
      end
      inValid = 1'b0;
      @(negedge clk);  // right padding step (R9)
    end
    if (last) repeat (w + 1) @(negedge clk);  // bottom flush (R5)
    repeat (4) @(negedge clk);
    check(gotQ.size() == expQ.size(), req, "output count",
          (NCH*ACCW)'(gotQ.size()), (NCH*ACCW)'(expQ.size()));
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] == expQ[i], req, $sformatf("output %0d", i), gotQ[i], expQ[i]);
  endtask

  task automatic runReset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R1", "outValid in reset", (NCH*ACCW)'(outValid), '0);
    end
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid idle after reset", (NCH*ACCW)'(outValid), '0);
  endtask

  task automatic runBypass();
    @(negedge clk);
    bypass = 1'b1; stride2 = 1'b0;
    gotQ.delete();
    for (int i = 0; i < 6; i++) begin
      logic [NCH*ACCW-1:0] e;
      inValid = 1'b1;
      for (int ch = 0; ch < NCH; ch++) begin
        int v = ((i*53 + ch*31) % 256) - 128;
        inData[ch*DW +: DW] = v[7:0];
        e[ch*ACCW +: ACCW] = v;
      end
      @(negedge clk);
      inValid = 1'b0;
      check(outValid == 1'b0, "R8", "one cycle after input", (NCH*ACCW)'(outValid), '0);
      @(negedge clk);
      check(outValid == 1'b1, "R8", "two cycles after input", (NCH*ACCW)'(outValid), 1);
      check(outData == e, "R8", "sign-extended pass-through", outData, e);
    end
    repeat (3) @(negedge clk);
    check(gotQ.size() == 6, "R8", "no extra outputs", (NCH*ACCW)'(gotQ.size()), 6);
    bypass = 1'b0;
  endtask

  initial begin
    runReset();
    runTile(5, 4, 1, 1, 0, 0, 0, 3,  "R2/R3/R4/R5/R7 full map");
    runTile(6, 5, 0, 0, 0, 0, 0, 17, "R4/R5 middle tile");
    runTile(4, 3, 1, 0, 0, 0, 0, 40, "R4/R5 top tile");
    runTile(4, 3, 0, 1, 0, 0, 0, 91, "R4/R5 bottom tile");
    runTile(7, 5, 1, 1, 1, 0, 0, 5,  "R6 stride two full map");
    runTile(6, 6, 0, 0, 1, 0, 0, 77, "R6 stride two middle tile");
    runTile(4, 3, 1, 1, 0, 1, 1, 0,  "R2 extreme values");
    runTile(1, 1, 1, 1, 0, 0, 0, 9,  "R3 single pixel");
    runTile(16, 3, 1, 1, 0, 0, 0, 60, "R3/R9 maximum width");
    runBypass();
    runTile(3, 4, 1, 1, 0, 0, 0, 123, "R2/R8 after bypass");
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule